// File: doc/BRIEF.md
# Dual Cascadable Up/Down Event Timer

This block holds two 16-bit up/down timers. Each one is set up through its own 8-bit control byte, which selects four things: whether the timer runs, which way it counts, where its count events and direction come from, and a power-of-two prescale. Count events can come from three places. One is an internal tick at one quarter of the system clock. Another is any edge, rising or falling, of an external clock pin. The third is quadrature decoding of the clock and direction pins taken as a pair. Software can load either count directly at any time.

Each timer gives out a one-cycle wrap strobe whenever its count rolls over in either direction. The second timer has two extra source modes that tie it to the first timer. In one mode it counts the first timer's wrap strobes, which makes a 32-bit cascade. In the other it steps in lock-step with the first timer and takes the first timer's direction. All external pins are brought into the clock domain through a two-flop synchronizer before any edge is detected.

Top module: `dual_event_timer`

## Requirements
- R1: After the synchronous active-low reset, both control bytes are 00h, both counts are 0000h and both wrap strobes are low. Both timers stay stopped until a control byte is written.
- R2: The control byte is laid out as follows: bit 7 is run, bit 6 is up (1 = count up, 0 = count down), bits 5:3 are the source mode and bits 2:0 are the prescale code. A written byte takes effect from the next rising edge. While run is 0, the count holds its value.
- R3: Mode 000 counts internal ticks, one tick every 4 system clocks, and takes its direction from the up bit.
- R4: Modes 001 and 101 count both the rising and the falling edges of the external clock pin, and take their direction from the up bit. A change on the pin shows in the count after the third rising clock edge following the change.
- R5: Modes 010 (internal tick) and 011 (external clock edges) take their direction from the synchronized direction pin, where 1 means count up.
- R6: Mode 111 decodes quadrature from the pair {clock pin, direction pin}. The transitions 00→10→11→01→00 each count up by one, and the reverse transitions each count down by one. A transition in which both pins change at once is ignored.
- R7: A prescale code p from 0 to 6 passes one count step for every 2^p source events. Code 7 behaves as code 6, which is divide by 64. Every write to the control byte clears the prescale phase.
- R8: A load write sets the count to the load value at the next edge. A load takes priority over a count step in the same cycle, and a load never raises the wrap strobe.
- R9: The wrap strobe is high for exactly the one cycle in which the count has just gone from FFFFh to 0000h counting up, or from 0000h to FFFFh counting down.
- R10: In mode 100 the second timer counts the first timer's wrap strobes. It uses its own up bit and its own prescaler for this.
- R11: In mode 110 the second timer steps on every step of the first timer and takes the first timer's direction. Its own prescaler is bypassed in this mode, but its own run bit must still be set.
- R12: In modes 100 and 110 the first timer never counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| t0_ctrl_we | input | 1 | Write strobe for the first timer's control byte |
| t0_ctrl_wdata | input | 8 | Control byte for the first timer |
| t0_load_we | input | 1 | Load strobe for the first timer's count |
| t0_load_data | input | 16 | Load value for the first timer |
| t0_ext_clk | input | 1 | External clock pin for the first timer (quadrature phase A) |
| t0_ext_dir | input | 1 | Direction pin for the first timer (quadrature phase B) |
| t0_count | output | 16 | Current count of the first timer |
| t0_wrap | output | 1 | Wrap strobe of the first timer |
| t1_ctrl_we | input | 1 | Write strobe for the second timer's control byte |
| t1_ctrl_wdata | input | 8 | Control byte for the second timer |
| t1_load_we | input | 1 | Load strobe for the second timer's count |
| t1_load_data | input | 16 | Load value for the second timer |
| t1_ext_clk | input | 1 | External clock pin for the second timer (quadrature phase A) |
| t1_ext_dir | input | 1 | Direction pin for the second timer (quadrature phase B) |
| t1_count | output | 16 | Current count of the second timer |
| t1_wrap | output | 1 | Wrap strobe of the second timer |

## Verification
Control and load writes show at the outputs one edge after the write strobe is taken. A pin change shows after the third edge: two synchronizer flops, then the edge detector feeding the count register. A cascaded step of the second timer shows one edge later still. The bench drives pins on falling edges and checks the pin-to-count latency and the wrap pulse at exactly those edges. For the internal tick, the timer is enabled for a window whose length is a whole multiple of 4·2^p edges. This makes the expected step count exact whatever the phase of the free-running tick.

// File: rtl/evt_timer_pkg.sv
// Package: shared control-byte layout and helpers for the event timers.
// Assumes an 8-bit control byte {run, up, mode[2:0], prescale[2:0]}.
package evt_timer_pkg;

    typedef enum logic [2:0] {
        MD_INT_UD   = 3'b000,
        MD_EXT_UD   = 3'b001,
        MD_INT_PIN  = 3'b010,
        MD_EXT_PIN  = 3'b011,
        MD_CASCADE  = 3'b100,
        MD_EXT_UD_B = 3'b101,
        MD_FOLLOW   = 3'b110,
        MD_QUAD     = 3'b111
    } src_mode_e;

    typedef struct packed {
        logic      run;
        logic      up;
        src_mode_e mode;
        logic [2:0] pre;
    } tctl_t;

    // Effective prescale shift: the top code is clamped to the one below it.
    function automatic logic [2:0] eff_shift(input logic [2:0] code);
        return (code == 3'b111) ? 3'b110 : code;
    endfunction

endpackage

// File: rtl/pin_sync.sv
// Module: pin_sync
// Brings an asynchronous pin into the clock domain through STAGES flops,
// then keeps one more flop of history so edges can be detected.
// Assumes STAGES >= 2.
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic prev,
    output logic changed
);
    logic [STAGES:0] sr;

    // Shift the pin through the synchronizer chain and the history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-1:0], pin};
    end

    assign level   = sr[STAGES-1];
    assign prev    = sr[STAGES];
    assign changed = level ^ prev;
endmodule

// File: rtl/quad_decoder.sv
// Module: quad_decoder
// Decodes one step of a two-phase Gray sequence. A single-phase change is
// a step; a change on both phases at once is invalid and produces nothing.
// Up order for {a,b}: 00 -> 10 -> 11 -> 01 -> 00.
module quad_decoder (
    input  logic a,
    input  logic b,
    input  logic pa,
    input  logic pb,
    output logic step,
    output logic up
);
    logic a_chg, b_chg;

    // Exactly one phase moved, and the direction follows which phase leads.
    always_comb begin
        a_chg = a ^ pa;
        b_chg = b ^ pb;
        step  = a_chg ^ b_chg;
        up    = a ^ pb;
    end
endmodule

// File: rtl/step_prescaler.sv
// Module: step_prescaler
// Passes one step for every 2^shift input events. The phase is cleared by clr.
// Assumes the code comes from a register that changes only when clr is high.
module step_prescaler
    import evt_timer_pkg::*;
#(
    parameter int PRE_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                event_i,
    input  logic [PRE_BITS-1:0] code,
    output logic                step_o
);
    localparam int MAX_SHIFT = (1 << PRE_BITS) - 2;

    logic [MAX_SHIFT-1:0] pcnt;
    logic [MAX_SHIFT-1:0] mask;

    // Build the wrap point of the phase counter from the effective shift.
    always_comb begin
        mask = MAX_SHIFT'((1 << eff_shift(code)) - 1);
    end

    // Advance the phase on each event and wrap it at the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       pcnt <= '0;
        else if (clr)     pcnt <= '0;
        else if (event_i) pcnt <= (pcnt == mask) ? '0 : pcnt + 1'b1;
    end

    assign step_o = event_i && (pcnt == mask);

    a_r7_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= mask);
endmodule

// File: rtl/timer_core.sv
// Module: timer_core
// One up/down timer: a control byte, source and direction selection, a
// prescaler, the count register and the wrap strobe. When IS_SECOND is set,
// the peer inputs enable the cascade and follow modes. Otherwise those two
// modes count nothing.
module timer_core
    import evt_timer_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int PRE_BITS    = 3,
    parameter int SYNC_STAGES = 2,
    parameter bit IS_SECOND   = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_int,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_wdata,
    input  logic             load_we,
    input  logic [WIDTH-1:0] load_data,
    input  logic             ext_clk,
    input  logic             ext_dir,
    input  logic             peer_wrap,
    input  logic             peer_step,
    input  logic             peer_up,
    output logic [WIDTH-1:0] count,
    output logic             wrap,
    output logic             step_o,
    output logic             up_o
);
    tctl_t ctrl_q;
    logic  clk_lvl, clk_prev, clk_chg;
    logic  dir_lvl, dir_prev, dir_chg;
    logic  q_step, q_up;
    logic  src_ev, src_up;
    logic  pre_step;
    logic  cas_ev, follow;
    logic  adv, adv_up;

    // Hold the control byte; it takes effect at the edge after the write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= tctl_t'(ctrl_wdata);
    end

    pin_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .pin(ext_clk),
        .level(clk_lvl), .prev(clk_prev), .changed(clk_chg)
    );

    pin_sync #(.STAGES(SYNC_STAGES)) u_sync_dir (
        .clk(clk), .rst_n(rst_n), .pin(ext_dir),
        .level(dir_lvl), .prev(dir_prev), .changed(dir_chg)
    );

    quad_decoder u_quad (
        .a(clk_lvl), .b(dir_lvl), .pa(clk_prev), .pb(dir_prev),
        .step(q_step), .up(q_up)
    );

    generate
        if (IS_SECOND) begin : g_peer
            assign cas_ev = peer_wrap;
            assign follow = (ctrl_q.mode == MD_FOLLOW);
        end else begin : g_solo
            logic unused_peer;
            assign unused_peer = peer_wrap ^ peer_step ^ peer_up;
            assign cas_ev      = 1'b0;
            assign follow      = 1'b0;
        end
    endgenerate

    // Select the raw count event and its direction for the current mode.
    always_comb begin
        src_ev = 1'b0;
        src_up = ctrl_q.up;
        case (ctrl_q.mode)
            MD_INT_UD:              src_ev = tick_int;
            MD_EXT_UD, MD_EXT_UD_B: src_ev = clk_chg;
            MD_INT_PIN:  begin src_ev = tick_int; src_up = dir_lvl; end
            MD_EXT_PIN:  begin src_ev = clk_chg;  src_up = dir_lvl; end
            MD_QUAD:     begin src_ev = q_step;   src_up = q_up;    end
            MD_CASCADE:             src_ev = cas_ev;
            default:                src_ev = 1'b0;
        endcase
    end

    step_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(ctrl_we), .event_i(src_ev),
        .code(ctrl_q.pre), .step_o(pre_step)
    );

    // Follow mode takes the peer's step and direction and bypasses the prescaler.
    always_comb begin
        adv    = ctrl_q.run && (follow ? peer_step : pre_step);
        adv_up = follow ? peer_up : src_up;
    end

    assign step_o = adv;
    assign up_o   = adv_up;

    // Update the count: a load wins over a step, and the wrap flag goes with the step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            wrap  <= 1'b0;
        end else if (load_we) begin
            count <= load_data;
            wrap  <= 1'b0;
        end else if (adv) begin
            count <= adv_up ? count + 1'b1 : count - 1'b1;
            wrap  <= adv_up ? (count == '1) : (count == '0);
        end else begin
            wrap  <= 1'b0;
        end
    end

    a_r8_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> (count == $past(load_data)));

    a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !load_we) |=> $stable(count));

    a_r9_wrap_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> ((count == '0) || (count == '1)));

    a_r4_single_steps: assert property (@(posedge clk) disable iff (!rst_n)
        !load_we |=> ((count == $past(count)) || (count == $past(count) + 1'b1)
                      || (count == $past(count) - 1'b1)));

    a_r6_double_change_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mode == MD_QUAD && clk_chg && dir_chg && !load_we) |=> $stable(count));

    generate
        if (!IS_SECOND) begin : g_first_chk
            a_r12_peer_modes_idle: assert property (@(posedge clk) disable iff (!rst_n)
                ((ctrl_q.mode == MD_CASCADE || ctrl_q.mode == MD_FOLLOW) && !load_we)
                |=> $stable(count));
        end
    endgenerate
endmodule

// File: rtl/dual_event_timer.sv
// Module: dual_event_timer
// Top level: a shared internal tick divider and two timers. The second timer
// can cascade from the first timer's wrap strobe or follow its steps.
// Assumes all external pins are asynchronous to clk.
module dual_event_timer #(
    parameter int WIDTH       = 16,
    parameter int PRE_BITS    = 3,
    parameter int SYNC_STAGES = 2,
    parameter int INT_DIV     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             t0_ctrl_we,
    input  logic [7:0]       t0_ctrl_wdata,
    input  logic             t0_load_we,
    input  logic [WIDTH-1:0] t0_load_data,
    input  logic             t0_ext_clk,
    input  logic             t0_ext_dir,
    output logic [WIDTH-1:0] t0_count,
    output logic             t0_wrap,
    input  logic             t1_ctrl_we,
    input  logic [7:0]       t1_ctrl_wdata,
    input  logic             t1_load_we,
    input  logic [WIDTH-1:0] t1_load_data,
    input  logic             t1_ext_clk,
    input  logic             t1_ext_dir,
    output logic [WIDTH-1:0] t1_count,
    output logic             t1_wrap
);
    localparam int DIV_W = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;

    logic [DIV_W-1:0] div_cnt;
    logic             tick_int;
    logic             t0_step, t0_up;
    logic             t1_step_unused, t1_up_unused;

    // Free-running divider that makes one internal tick every INT_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n)                                div_cnt <= '0;
        else if (div_cnt == DIV_W'(INT_DIV - 1))   div_cnt <= '0;
        else                                       div_cnt <= div_cnt + 1'b1;
    end

    assign tick_int = (div_cnt == DIV_W'(INT_DIV - 1));

    timer_core #(.WIDTH(WIDTH), .PRE_BITS(PRE_BITS), .SYNC_STAGES(SYNC_STAGES),
                 .IS_SECOND(1'b0)) u_first (
        .clk(clk), .rst_n(rst_n), .tick_int(tick_int),
        .ctrl_we(t0_ctrl_we), .ctrl_wdata(t0_ctrl_wdata),
        .load_we(t0_load_we), .load_data(t0_load_data),
        .ext_clk(t0_ext_clk), .ext_dir(t0_ext_dir),
        .peer_wrap(1'b0), .peer_step(1'b0), .peer_up(1'b0),
        .count(t0_count), .wrap(t0_wrap), .step_o(t0_step), .up_o(t0_up)
    );

    timer_core #(.WIDTH(WIDTH), .PRE_BITS(PRE_BITS), .SYNC_STAGES(SYNC_STAGES),
                 .IS_SECOND(1'b1)) u_second (
        .clk(clk), .rst_n(rst_n), .tick_int(tick_int),
        .ctrl_we(t1_ctrl_we), .ctrl_wdata(t1_ctrl_wdata),
        .load_we(t1_load_we), .load_data(t1_load_data),
        .ext_clk(t1_ext_clk), .ext_dir(t1_ext_dir),
        .peer_wrap(t0_wrap), .peer_step(t0_step), .peer_up(t0_up),
        .count(t1_count), .wrap(t1_wrap),
        .step_o(t1_step_unused), .up_o(t1_up_unused)
    );

    a_r3_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick_int |=> !tick_int);
endmodule

// File: tb/sim_dual_event_timer.sv
module sim_dual_event_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        t0_ctrl_we = 1'b0, t1_ctrl_we = 1'b0;
    logic [7:0]  t0_ctrl_wdata = '0, t1_ctrl_wdata = '0;
    logic        t0_load_we = 1'b0, t1_load_we = 1'b0;
    logic [15:0] t0_load_data = '0, t1_load_data = '0;
    logic        c0 = 1'b0, d0 = 1'b0, c1 = 1'b0, d1 = 1'b0;
    logic [15:0] t0_count, t1_count;
    logic        t0_wrap, t1_wrap;
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    dual_event_timer u0 (
        .clk(clk), .rst_n(rst_n),
        .t0_ctrl_we(t0_ctrl_we), .t0_ctrl_wdata(t0_ctrl_wdata),
        .t0_load_we(t0_load_we), .t0_load_data(t0_load_data),
        .t0_ext_clk(c0), .t0_ext_dir(d0),
        .t0_count(t0_count), .t0_wrap(t0_wrap),
        .t1_ctrl_we(t1_ctrl_we), .t1_ctrl_wdata(t1_ctrl_wdata),
        .t1_load_we(t1_load_we), .t1_load_data(t1_load_data),
        .t1_ext_clk(c1), .t1_ext_dir(d1),
        .t1_count(t1_count), .t1_wrap(t1_wrap)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] cb(input bit run, input bit up, input int mode, input int p);
        return {run, up, 3'(mode), 3'(p)};
    endfunction

    task automatic wr_ctrl(input int t, input logic [7:0] v);
        @(negedge clk);
        if (t == 0) begin t0_ctrl_we = 1'b1; t0_ctrl_wdata = v; end
        else        begin t1_ctrl_we = 1'b1; t1_ctrl_wdata = v; end
        @(negedge clk);
        t0_ctrl_we = 1'b0; t1_ctrl_we = 1'b0;
    endtask

    task automatic load(input int t, input logic [15:0] v);
        @(negedge clk);
        if (t == 0) begin t0_load_we = 1'b1; t0_load_data = v; end
        else        begin t1_load_we = 1'b1; t1_load_data = v; end
        @(negedge clk);
        t0_load_we = 1'b0; t1_load_we = 1'b0;
    endtask

    task automatic tgl0(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) c0 = ~c0;
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic quad0(input logic a, input logic b);
        @(negedge clk) begin c0 = a; d0 = b; end
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and timers stay stopped
        chk("R1 count0 after reset", t0_count, 0);
        chk("R1 count1 after reset", t1_count, 0);
        chk("R1 wraps after reset", {t0_wrap, t1_wrap}, 0);
        repeat (40) @(negedge clk);
        chk("R1 timer stopped after reset", t0_count, 0);

        // R3 / R7: internal tick sweep over every prescale code, both directions
        for (int p = 0; p < 8; p++) begin
            for (int u = 0; u < 2; u++) begin
                int eff, len;
                eff = (p == 7) ? 6 : p;
                len = 4 * (1 << eff) * 3;
                wr_ctrl(0, 8'h00);
                load(0, 16'h8000);
                wr_ctrl(0, cb(1, u[0], 0, p));
                repeat (len) @(negedge clk);
                chk($sformatf("R3 R7 internal p=%0d up=%0d", p, u), t0_count,
                    (u == 1) ? 32'h8003 : 32'h7FFD);
            end
        end
        // R7: reserved code acts as divide by 64 over two periods
        wr_ctrl(0, 8'h00);
        load(0, 16'h0100);
        wr_ctrl(0, cb(1, 1, 0, 7));
        repeat (512) @(negedge clk);
        chk("R7 reserved code as 64", t0_count, 16'h0102);

        // R8: load while running wins over counting
        wr_ctrl(0, cb(1, 1, 0, 0));
        load(0, 16'h1234);
        chk("R8 load while running", t0_count, 16'h1234);
        chk("R8 no wrap on load", t0_wrap, 0);

        // R2: run bit clear holds the count
        wr_ctrl(0, cb(0, 1, 0, 0));
        load(0, 16'h0400);
        repeat (64) @(negedge clk);
        chk("R2 stopped holds", t0_count, 16'h0400);

        // R4: external clock, latency and both edges
        wr_ctrl(0, cb(1, 1, 1, 0));
        load(0, 16'h0100);
        @(negedge clk) c0 = ~c0;
        @(negedge clk);
        chk("R4 no change after 1 edge", t0_count, 16'h0100);
        @(negedge clk);
        chk("R4 no change after 2 edges", t0_count, 16'h0100);
        @(negedge clk);
        chk("R4 change after 3 edges", t0_count, 16'h0101);
        tgl0(6);
        chk("R4 both edges counted", t0_count, 16'h0107);
        wr_ctrl(0, cb(1, 0, 5, 0));
        load(0, 16'h0050);
        tgl0(5);
        chk("R4 mode 101 down", t0_count, 16'h004B);

        // R5: direction pin
        @(negedge clk) d0 = 1'b0;
        wr_ctrl(0, cb(1, 1, 3, 0));
        load(0, 16'h0200);
        tgl0(3);
        chk("R5 ext with dir pin low", t0_count, 16'h01FD);
        @(negedge clk) d0 = 1'b1;
        repeat (4) @(negedge clk);
        tgl0(3);
        chk("R5 ext with dir pin high", t0_count, 16'h0200);
        @(negedge clk) d0 = 1'b0;
        repeat (4) @(negedge clk);
        wr_ctrl(0, 8'h00);
        load(0, 16'h0010);
        wr_ctrl(0, cb(1, 1, 2, 0));
        repeat (8) @(negedge clk);
        chk("R5 internal with dir pin low", t0_count, 16'h000E);

        // R7: prescale on external events and phase clear on control write
        wr_ctrl(0, cb(1, 1, 1, 2));
        load(0, 16'h0000);
        tgl0(8);
        chk("R7 ext divide by 4", t0_count, 16'h0002);
        tgl0(2);
        wr_ctrl(0, cb(1, 1, 1, 2));
        tgl0(3);
        chk("R7 phase cleared by write", t0_count, 16'h0002);

        // R9: wrap up and down
        wr_ctrl(0, cb(1, 1, 1, 0));
        load(0, 16'hFFFF);
        @(negedge clk) c0 = ~c0;
        repeat (2) @(negedge clk);
        chk("R9 wrap low before step", t0_wrap, 0);
        @(negedge clk);
        chk("R9 up wrap count", t0_count, 0);
        chk("R9 up wrap strobe", t0_wrap, 1);
        @(negedge clk);
        chk("R9 wrap one cycle", t0_wrap, 0);
        wr_ctrl(0, cb(1, 0, 1, 0));
        load(0, 16'h0000);
        @(negedge clk) c0 = ~c0;
        repeat (3) @(negedge clk);
        chk("R9 down wrap count", t0_count, 16'hFFFF);
        chk("R9 down wrap strobe", t0_wrap, 1);

        // R6: quadrature
        wr_ctrl(0, 8'h00);
        quad0(0, 0);
        load(0, 16'h1000);
        wr_ctrl(0, cb(1, 0, 7, 0));
        for (int r = 0; r < 2; r++) begin
            quad0(1, 0); quad0(1, 1); quad0(0, 1); quad0(0, 0);
        end
        chk("R6 quad up sequence", t0_count, 16'h1008);
        quad0(0, 1); quad0(1, 1); quad0(1, 0); quad0(0, 0);
        chk("R6 quad down sequence", t0_count, 16'h1004);
        quad0(1, 1); quad0(0, 0);
        chk("R6 quad double change ignored", t0_count, 16'h1004);

        // R10: cascade from first timer wrap
        wr_ctrl(1, cb(1, 1, 4, 0));
        load(1, 16'h0007);
        wr_ctrl(0, cb(1, 1, 1, 0));
        load(0, 16'hFFFE);
        tgl0(2);
        chk("R10 first wrapped", t0_count, 0);
        chk("R10 second counted wrap", t1_count, 16'h0008);
        tgl0(3);
        chk("R10 second ignores non-wrap steps", t1_count, 16'h0008);

        // R11: follow mode
        wr_ctrl(1, cb(1, 0, 6, 0));
        load(1, 16'h0500);
        wr_ctrl(0, cb(1, 1, 1, 1));
        load(0, 16'h0010);
        tgl0(4);
        chk("R11 first with prescale 2", t0_count, 16'h0012);
        chk("R11 second follows up", t1_count, 16'h0502);
        wr_ctrl(0, cb(1, 0, 1, 1));
        tgl0(2);
        chk("R11 second follows down", t1_count, 16'h0501);
        wr_ctrl(1, cb(0, 0, 6, 0));
        tgl0(2);
        chk("R11 second needs own run", t1_count, 16'h0501);

        // R12: peer modes on the first timer do nothing
        wr_ctrl(0, cb(1, 1, 4, 0));
        load(0, 16'h0077);
        tgl0(4);
        repeat (32) @(negedge clk);
        chk("R12 mode 100 on first idle", t0_count, 16'h0077);
        wr_ctrl(0, cb(1, 1, 6, 0));
        tgl0(4);
        chk("R12 mode 110 on first idle", t0_count, 16'h0077);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule